// File: doc/BRIEF.md
# Run-Length Sprite Pixel Renderer

This block draws one sprite over a raster video stream. For every pixel the stream presents (coordinates plus a valid strobe), it decides whether the pixel falls inside the sprite's bounding box. If it does, it produces that pixel's colour from a run-length description of the image: a list of entries, each holding a run length, a colour code and a mask bit. The entries live in an external buffer that the block reads through a combinational address/data port. The block walks those entries in raster order, counting each run down pixel by pixel, so no bitmap is ever indexed.

Three outputs are produced per pixel. The enable output says the background should be replaced. The inside output says the pixel belongs to the object, and it follows the entry's mask bit. The colour output carries the run's colour. One colour code is reserved as transparent and never asserts enable, so an object can have see-through regions that still count as inside. Integer magnification is applied at draw time. Each run is stretched by the horizontal factor, and each source line is replayed by the vertical factor. The box dimensions given at the ports are the already-scaled screen dimensions. A vertical sync pulse restarts the walk at the first entry.

The pixel stream has a valid strobe and no ready: video cannot be stalled, so the block applies no back-pressure and accepts every valid pixel. Each result appears one clock after its pixel, with its own valid flag. Cycles with the valid strobe low are bubbles that carry no pixel and change nothing.

Top module: `sprite_rle_render`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, out_enable, out_inside and out_color are all 0.
- R2: out_valid is 1 exactly one clock after a cycle with pix_valid=1 and vsync=0, and 0 otherwise. When out_valid is 0, the other outputs are 0. There is no ready signal and no back-pressure.
- R3: A valid pixel outside the box, meaning x < box_x, x >= box_x+box_w, y < box_y or y >= box_y+box_h, gives out_enable=0, out_inside=0 and out_color=0.
- R4: Entries are read in index order starting at rd_addr=0. Each entry covers rd_len*scale_x consecutive in-box pixels of the current line and shows its colour on out_color. Every box line begins with a fresh entry.
- R5: An in-box pixel whose run colour equals the TRANSP code (0 in the bench) gives out_enable=0. Any other colour gives out_enable=1.
- R6: out_inside for an in-box pixel equals the run's mask bit, whatever its colour, including transparent runs.
- R7: Bubble cycles (pix_valid=0) and out-of-box pixels leave the walk state unchanged, so a run resumes exactly where it stopped.
- R8: Each source line's entries are replayed scale_y times on consecutive box lines before the walk moves to the next line's entries.
- R9: A cycle with vsync=1 restarts the walk at entry 0 with the line-repeat count cleared, and its pixel is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Frame start pulse; restarts the walk |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_x | input | XW | Pixel column |
| pix_y | input | YW | Pixel row |
| box_x | input | XW | Box left column |
| box_y | input | YW | Box top row |
| box_w | input | XW | Box width in screen pixels (scaled) |
| box_h | input | YW | Box height in screen pixels (scaled) |
| scale_x | input | SW | Horizontal magnification, at least 1 |
| scale_y | input | SW | Vertical magnification, at least 1 |
| rd_addr | output | AW | Entry index being read |
| rd_len | input | LW | Run length of the addressed entry, at least 1 |
| rd_color | input | CW | Colour code of the addressed entry |
| rd_mask | input | 1 | Mask bit of the addressed entry |
| out_valid | output | 1 | Result valid, one clock after the pixel |
| out_enable | output | 1 | Replace the background |
| out_inside | output | 1 | Pixel belongs to the object |
| out_color | output | CW | Colour of the pixel |

## Verification
The bench builds the block with 6-bit coordinates, 4-bit lengths and colours, 2-bit scale factors and an eight-entry buffer. That keeps a whole frame down to a few hundred pixels. A five-entry, four-by-three test image then fits and can be swept under every scale pair from 1x1 to 3x3, at boxes touching the top-left and bottom-right corners of a 20x14 frame. Every frame is drawn twice without reset, to exercise the restart on vertical sync. Bubbles are scattered through the raster, including mid-run, so that held run state is reached both inside and outside the box.

// File: rtl/sprite_rle_pkg.sv
package sprite_rle_pkg;
  // Result of comparing one pixel against the sprite bounding box.
  typedef struct packed {
    logic hit;       // pixel lies inside the box
    logic last_col;  // pixel is the rightmost column of the box
  } box_hit_t;
endpackage

// File: rtl/sprite_box_cmp.sv
module sprite_box_cmp
  import sprite_rle_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 10
) (
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [XW-1:0] box_x,
  input  logic [YW-1:0] box_y,
  input  logic [XW-1:0] box_w,
  input  logic [YW-1:0] box_h,
  output box_hit_t      res
);
  // Offsets from the box origin; the top bit flags a pixel left of / above it.
  logic [XW:0] dx;
  logic [YW:0] dy;
  logic        in_x, in_y;

  always_comb begin
    dx   = {1'b0, pix_x} - {1'b0, box_x};
    dy   = {1'b0, pix_y} - {1'b0, box_y};
    in_x = !dx[XW] && (dx[XW-1:0] < box_w);
    in_y = !dy[YW] && (dy[YW-1:0] < box_h);
    res.hit      = in_x && in_y;
    res.last_col = in_x && in_y && (dx[XW-1:0] == box_w - XW'(1));
  end
endmodule

// File: rtl/sprite_run_walker.sv
module sprite_run_walker #(
  parameter int LW = 8,
  parameter int CW = 8,
  parameter int SW = 3,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic          last_col,
  input  logic [SW-1:0] scale_x,
  input  logic [SW-1:0] scale_y,
  output logic [AW-1:0] rd_addr,
  input  logic [LW-1:0] rd_len,
  input  logic [CW-1:0] rd_color,
  input  logic          rd_mask,
  output logic [CW-1:0] run_color,
  output logic          run_mask
);
  localparam int CNTW = LW + SW;

  logic [CNTW-1:0] cnt;         // pixels left in the current run
  logic [AW-1:0]   ptr;         // next entry to fetch
  logic [AW-1:0]   line_start;  // first entry of the current source line
  logic [SW-1:0]   rep;         // replays done of the current source line
  logic [CW-1:0]   hold_color;
  logic            hold_mask;

  logic            fetch;
  logic [CNTW-1:0] scaled_len;
  logic [AW-1:0]   ptr_adv;
  logic            line_done_all;

  assign rd_addr = ptr;

  always_comb begin
    fetch         = (cnt == '0);
    scaled_len    = CNTW'(rd_len) * CNTW'(scale_x);
    ptr_adv       = fetch ? ptr + AW'(1) : ptr;
    line_done_all = (rep == scale_y - SW'(1));
    run_color     = fetch ? rd_color : hold_color;
    run_mask      = fetch ? rd_mask  : hold_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      ptr        <= '0;
      line_start <= '0;
      rep        <= '0;
      hold_color <= '0;
      hold_mask  <= 1'b0;
    end else if (restart) begin
      cnt        <= '0;
      ptr        <= '0;
      line_start <= '0;
      rep        <= '0;
    end else if (step) begin
      if (fetch) begin
        hold_color <= rd_color;
        hold_mask  <= rd_mask;
        cnt        <= scaled_len - CNTW'(1);
      end else begin
        cnt <= cnt - CNTW'(1);
      end
      if (last_col) begin
        // Runs end on the right edge: the next line starts on a fresh entry.
        cnt <= '0;
        if (line_done_all) begin
          rep        <= '0;
          line_start <= ptr_adv;
          ptr        <= ptr_adv;
        end else begin
          rep <= rep + SW'(1);
          ptr <= line_start;
        end
      end else begin
        ptr <= ptr_adv;
      end
    end
  end
endmodule

// File: rtl/sprite_pixel_out.sv
module sprite_pixel_out #(
  parameter int          CW     = 8,
  parameter logic [CW-1:0] TRANSP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          hit,
  input  logic [CW-1:0] color,
  input  logic          mask,
  output logic          out_valid,
  output logic          out_enable,
  output logic          out_inside,
  output logic [CW-1:0] out_color
);
  logic draw;
  assign draw = go && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_enable <= 1'b0;
      out_inside <= 1'b0;
      out_color  <= '0;
    end else begin
      out_valid  <= go;
      out_enable <= draw && (color != TRANSP);
      out_inside <= draw && mask;
      out_color  <= draw ? color : '0;
    end
  end
endmodule

// File: rtl/sprite_rle_render.sv
module sprite_rle_render
  import sprite_rle_pkg::*;
#(
  parameter int            XW     = 11,
  parameter int            YW     = 10,
  parameter int            LW     = 8,
  parameter int            CW     = 8,
  parameter int            SW     = 3,
  parameter int            DEPTH  = 64,
  parameter logic [CW-1:0] TRANSP = '0,
  localparam int           AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic          pix_valid,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [XW-1:0] box_x,
  input  logic [YW-1:0] box_y,
  input  logic [XW-1:0] box_w,
  input  logic [YW-1:0] box_h,
  input  logic [SW-1:0] scale_x,
  input  logic [SW-1:0] scale_y,
  output logic [AW-1:0] rd_addr,
  input  logic [LW-1:0] rd_len,
  input  logic [CW-1:0] rd_color,
  input  logic          rd_mask,
  output logic          out_valid,
  output logic          out_enable,
  output logic          out_inside,
  output logic [CW-1:0] out_color
);
  box_hit_t      bh;
  logic          go;
  logic [CW-1:0] run_color;
  logic          run_mask;

  // A pixel arriving with the frame pulse is dropped.
  assign go = pix_valid && !vsync;

  sprite_box_cmp #(.XW(XW), .YW(YW)) u_box (
    .pix_x (pix_x), .pix_y (pix_y),
    .box_x (box_x), .box_y (box_y),
    .box_w (box_w), .box_h (box_h),
    .res   (bh)
  );

  sprite_run_walker #(.LW(LW), .CW(CW), .SW(SW), .AW(AW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (vsync),
    .step      (go && bh.hit),
    .last_col  (bh.last_col),
    .scale_x   (scale_x),
    .scale_y   (scale_y),
    .rd_addr   (rd_addr),
    .rd_len    (rd_len),
    .rd_color  (rd_color),
    .rd_mask   (rd_mask),
    .run_color (run_color),
    .run_mask  (run_mask)
  );

  sprite_pixel_out #(.CW(CW), .TRANSP(TRANSP)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .hit        (bh.hit),
    .color      (run_color),
    .mask       (run_mask),
    .out_valid  (out_valid),
    .out_enable (out_enable),
    .out_inside (out_inside),
    .out_color  (out_color)
  );
endmodule

// File: rtl/sprite_rle_chk.sv
module sprite_rle_chk #(
  parameter int            XW     = 11,
  parameter int            YW     = 10,
  parameter int            CW     = 8,
  parameter int            AW     = 6,
  parameter logic [CW-1:0] TRANSP = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync,
  input logic          pix_valid,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y,
  input logic [XW-1:0] box_x,
  input logic [YW-1:0] box_y,
  input logic [XW-1:0] box_w,
  input logic [YW-1:0] box_h,
  input logic [AW-1:0] rd_addr,
  input logic          out_valid,
  input logic          out_enable,
  input logic          out_inside,
  input logic [CW-1:0] out_color
);
  logic outside;
  assign outside = ({1'b0, pix_x} < {1'b0, box_x}) ||
                   ({1'b0, pix_x} >= {1'b0, box_x} + {1'b0, box_w}) ||
                   ({1'b0, pix_y} < {1'b0, box_y}) ||
                   ({1'b0, pix_y} >= {1'b0, box_y} + {1'b0, box_h});

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !vsync) |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && !vsync) |=> (!out_valid && !out_enable && !out_inside && out_color == '0));

  assert_outside_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !vsync && outside) |=> (!out_enable && !out_inside && out_color == '0));

  assert_transp_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_enable |-> (out_color != TRANSP));

  assert_hold_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync && (!pix_valid || outside)) |=> $stable(rd_addr));

  assert_frame_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (rd_addr == '0));
endmodule

bind sprite_rle_render sprite_rle_chk #(
  .XW(XW), .YW(YW), .CW(CW), .AW(AW), .TRANSP(TRANSP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .pix_valid(pix_valid),
  .pix_x(pix_x), .pix_y(pix_y), .box_x(box_x), .box_y(box_y),
  .box_w(box_w), .box_h(box_h), .rd_addr(rd_addr),
  .out_valid(out_valid), .out_enable(out_enable),
  .out_inside(out_inside), .out_color(out_color)
);

// File: tb/tb_sprite_rle_render.sv
`timescale 1ns/1ps
module tb_sprite_rle_render;
  localparam int XW = 6, YW = 6, LW = 4, CW = 4, SW = 2, DEPTH = 8, AW = 3;
  localparam int FW = 20, FH = 14, IW = 4, IH = 3, NE = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vsync, pix_valid;
  logic [XW-1:0] pix_x, box_x, box_w;
  logic [YW-1:0] pix_y, box_y, box_h;
  logic [SW-1:0] scale_x, scale_y;
  logic [AW-1:0] rd_addr;
  logic [LW-1:0] rd_len;
  logic [CW-1:0] rd_color;
  logic          rd_mask;
  logic          out_valid, out_enable, out_inside;
  logic [CW-1:0] out_color;

  always #2 clk = ~clk;

  // Test image, 4x3 source pixels: lengths, colours (0 = transparent), masks.
  int e_len [NE] = '{2, 2, 1, 3, 4};
  int e_col [NE] = '{5, 0, 3, 0, 7};
  int e_msk [NE] = '{1, 0, 1, 1, 0};
  int l_first [IH+1] = '{0, 2, 4, 5};

  always_comb begin
    if (int'(rd_addr) < NE) begin
      rd_len   = LW'(e_len[rd_addr]);
      rd_color = CW'(e_col[rd_addr]);
      rd_mask  = e_msk[rd_addr][0];
    end else begin
      rd_len = '0; rd_color = '0; rd_mask = 1'b0;
    end
  end

  sprite_rle_render #(.XW(XW), .YW(YW), .LW(LW), .CW(CW), .SW(SW),
                      .DEPTH(DEPTH), .TRANSP(4'd0)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int cur_frame = 0;

  // Expected result of the pixel driven in the previous cycle.
  logic e_valid, e_en, e_in; int e_c; string e_tag;

  task automatic expect_check();
    checks++;
    if (out_valid !== e_valid || out_enable !== e_en || out_inside !== e_in ||
        int'(out_color) != e_c) begin
      fails++;
      $display("FAIL %s: got v=%0b en=%0b in=%0b c=%0d expected v=%0b en=%0b in=%0b c=%0d",
               e_tag, out_valid, out_enable, out_inside, out_color,
               e_valid, e_en, e_in, e_c);
    end
  endtask

  // Source pixel colour/mask by walking the run table of that line.
  task automatic src_pixel(input int col, input int row, output int c, output int m);
    int acc = 0;
    c = 0; m = 0;
    for (int e = l_first[row]; e < l_first[row+1]; e++) begin
      if (col >= acc && col < acc + e_len[e]) begin c = e_col[e]; m = e_msk[e]; end
      acc += e_len[e];
    end
  endtask

  task automatic cycle(input logic v, input logic vs, input int x, input int y,
                       input int bx, input int by, input int sx, input int sy,
                       input bit after_gap);
    int c, m; bit inb;
    pix_valid = v; vsync = vs; pix_x = XW'(x); pix_y = YW'(y);
    inb = (x >= bx) && (x < bx + IW*sx) && (y >= by) && (y < by + IH*sy);
    e_valid = v && !vs; e_en = 0; e_in = 0; e_c = 0;
    if (!e_valid) e_tag = vs ? "R9 vsync drop" : "R2 bubble";
    else if (!inb) e_tag = "R3 outside";
    else begin
      src_pixel((x-bx)/sx, (y-by)/sy, c, m);
      e_en = (c != 0); e_in = m[0]; e_c = c;
      if (after_gap) e_tag = "R7 resume";
      else if (cur_frame == 1 && y == by) e_tag = "R9 restart";
      else if (c == 0 && m != 0) e_tag = "R6 transparent mask";
      else if (c == 0) e_tag = "R5 transparent";
      else if (m == 0) e_tag = "R6 unmasked";
      else if ((y-by) % sy != 0) e_tag = "R8 replay";
      else e_tag = "R4 run";
    end
    @(posedge clk); #1;
    expect_check();
  endtask

  initial begin
    rst_n = 0; vsync = 0; pix_valid = 0; pix_x = '0; pix_y = '0;
    box_x = '0; box_y = '0; box_w = '0; box_h = '0; scale_x = 1; scale_y = 1;
    repeat (3) @(posedge clk);
    #1;
    e_valid = 0; e_en = 0; e_in = 0; e_c = 0; e_tag = "R1 in reset";
    expect_check();
    rst_n = 1;
    @(posedge clk); #1;
    e_tag = "R1 after reset";
    expect_check();
    for (int sx = 1; sx <= 3; sx++)
      for (int sy = 1; sy <= 3; sy++)
        for (int pos = 0; pos < 2; pos++) begin
          int bx = (pos == 0) ? 0 : FW - IW*sx;
          int by = (pos == 0) ? 0 : FH - IH*sy;
          scale_x = SW'(sx); scale_y = SW'(sy);
          box_x = XW'(bx); box_y = YW'(by);
          box_w = XW'(IW*sx); box_h = YW'(IH*sy);
          for (int f = 0; f < 2; f++) begin
            cur_frame = f;
            // Pixel on the pulse cycle is dropped (R9).
            cycle(1, 1, bx, by, bx, by, sx, sy, 0);
            for (int y = 0; y < FH; y++)
              for (int x = 0; x < FW; x++) begin
                bit gap = ((x*5 + y*3 + f + sx) % 7) == 0;
                if (gap) cycle(0, 0, bx, by, bx, by, sx, sy, 0);
                cycle(1, 0, x, y, bx, by, sx, sy, gap);
              end
          end
        end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule